// File: doc/BRIEF.md
# Interrupt Table Service Port

This block sits next to the memory controller and accepts message writes aimed at an interrupt address window. The write address picks one of several interrupt tables and whether the message raises or drops a pending bit. The message word carries a payload, an ISR number, a priority and a privilege level. The low bits of the ISR number pick the pending bit. Device messages and processor-to-processor messages use the same format and arrive on parallel write ports. Pending bits are stored in the table whether or not any core is currently watching it.

When a raise operation changes a table's pending mask, a notification is broadcast: the table's memory address together with its 64-bit pending mask. Each core has a snoop filter that compares the broadcast address with its own table-pointer input and latches the mask only on a match. Software can instead poll the window with reads. A read returns a table's mask and claims it, which clears the returned bits. Level-style sources use a raise message to assert and a drop message to deassert.

The broadcaster is a two-state machine (`BC_IDLE`, `BC_SEND`). Transitions: `BC_IDLE` to `BC_SEND` when any table is marked changed; `BC_SEND` stays in `BC_SEND` while changed tables remain; `BC_SEND` to `BC_IDLE` when none remain; reset forces `BC_IDLE`.

Top module: `itsp_service_port`

## Requirements
- R1: After reset every pending mask is zero, and `bc_valid`, `rd_rsp_valid` and every `core_cap_valid` are low.
- R2: A write hits the window only when the address is `APT_BASE + 16*t + 8*c` for table t (address bits 5:4) and drop flag c (address bit 3), with bits 11:6 and 2:0 zero and bits 31:12 equal to those of `APT_BASE`. A raise (c=0) sets bit `isr[5:0]` of table t, and a drop (c=1) clears it. Writes outside the window change nothing.
- R3: A raised bit stays pending and readable even when no core's table pointer matches the table.
- R4: A core asserts `core_cap_valid` and presents the broadcast mask one cycle after a broadcast, and only when `bc_addr` equals its table pointer.
- R5: A raise that changes a table's mask produces a broadcast in the following cycle, with `bc_addr = TBL_BASE + t*TBL_STRIDE` and the table's mask. A raise of a bit that is already set, or a drop, produces no broadcast.
- R6: When several tables are marked changed, one broadcast is issued per cycle, in round-robin order starting after the last table served. After reset the search starts at table 0.
- R7: Every read gets a response one cycle later. A read inside the window returns the table's mask and clears those bits. A read outside the window returns zero.
- R8: Operations in one cycle apply in a fixed order: the read claim first, then write port 0, then write port 1. The later operation wins on a shared bit.
- R9: The payload, priority, privilege and ISR bits 7:6 do not affect which bit is touched. Message layout: payload bits 31:0, ISR bits 39:32, priority bits 42:40, privilege bits 44:43.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | NUM_WR | Write strobe per port; port 0 is ordered first |
| wr_addr | input | NUM_WR*ADDR_W | Write address per port |
| wr_data | input | NUM_WR*64 | Interrupt message per port |
| rd_valid | input | 1 | Poll read strobe |
| rd_addr | input | ADDR_W | Poll read address; bits 5:4 select the table |
| rd_rsp_valid | output | 1 | Read response strobe |
| rd_rsp_data | output | MASK_W | Claimed pending mask |
| bc_valid | output | 1 | Broadcast strobe |
| bc_addr | output | ADDR_W | Memory address of the broadcast table |
| bc_mask | output | MASK_W | Pending mask of the broadcast table |
| core_tbl_ptr | input | NUM_CORES*ADDR_W | Table-pointer value of each core |
| core_cap_valid | output | NUM_CORES | Per-core capture strobe |
| core_cap_mask | output | NUM_CORES*MASK_W | Per-core captured mask |

## Verification
The hardest situations to reach are same-cycle collisions: a read claim and a raise hitting one table together, or a raise on one port and a drop on the other hitting one bit. Directed tasks drive both write ports and the read strobe on the same clock edge with chosen addresses. A second read then exposes the surviving bits. A check that no broadcast follows shows whether the mask was seen as changed. Round-robin order is checked after a fresh reset, so the search pointer starts from a known table.

// File: rtl/itsp_pkg.sv
package itsp_pkg;

    localparam int MSG_W      = 64;
    localparam int PAYLOAD_LSB = 0;
    localparam int ISR_LSB    = 32;
    localparam int ISR_W      = 8;
    localparam int PRIO_LSB   = 40;
    localparam int PRIO_W     = 3;
    localparam int PRIV_LSB   = 43;
    localparam int PRIV_W     = 2;
    localparam int OP_BIT     = 3;
    localparam int TSEL_LSB   = 4;

    typedef enum logic [0:0] {
        BC_IDLE = 1'b0,
        BC_SEND = 1'b1
    } bc_state_e;

endpackage

// File: rtl/itsp_apt_decode.sv
module itsp_apt_decode #(
    parameter int              ADDR_W   = 32,
    parameter int              APT_BITS = 12,
    parameter int              TW       = 2,
    parameter logic [ADDR_W-1:0] APT_BASE = 32'hFEE0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              clr,
    output logic [TW-1:0]     tbl
);
    import itsp_pkg::*;

    localparam int MID_LSB = TSEL_LSB + TW;

    logic upper_ok;
    logic mid_ok;
    logic low_ok;

    always_comb begin
        upper_ok = (addr[ADDR_W-1:APT_BITS] == APT_BASE[ADDR_W-1:APT_BITS]);
        mid_ok   = (addr[APT_BITS-1:MID_LSB] == '0);
        low_ok   = (addr[OP_BIT-1:0] == '0);
        hit      = upper_ok && mid_ok && low_ok;
        clr      = addr[OP_BIT];
        tbl      = addr[TSEL_LSB +: TW];
    end

endmodule

// File: rtl/itsp_table_bank.sv
module itsp_table_bank #(
    parameter int NT  = 4,
    parameter int MW  = 64,
    parameter int NWR = 2,
    localparam int TW = $clog2(NT),
    localparam int BW = $clog2(MW)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NWR-1:0]          wr_hit,
    input  logic [NWR-1:0]          wr_clr,
    input  logic [NWR-1:0][TW-1:0]  wr_tbl,
    input  logic [NWR-1:0][BW-1:0]  wr_bit,
    input  logic                    rd_valid,
    input  logic                    rd_hit,
    input  logic [TW-1:0]           rd_tbl,
    input  logic                    srv_valid,
    input  logic [TW-1:0]           srv_tbl,
    output logic [NT-1:0][MW-1:0]   pend,
    output logic [NT-1:0]           dirty,
    output logic                    rd_rsp_valid,
    output logic [MW-1:0]           rd_rsp_data
);

    logic [NT-1:0][MW-1:0] pend_q, pend_d, after_rd;
    logic [NT-1:0]         dirty_q, dirty_d;
    logic                  rsp_v_q;
    logic [MW-1:0]         rsp_d_q;
    logic                  claim;
    logic                  wr_to_rd;

    always_comb begin
        claim    = rd_valid && rd_hit;
        after_rd = pend_q;
        if (claim) begin
            after_rd[rd_tbl] = '0;
        end
        pend_d = after_rd;
        for (int w = 0; w < NWR; w++) begin
            if (wr_hit[w]) begin
                pend_d[wr_tbl[w]][wr_bit[w]] = !wr_clr[w];
            end
        end
        dirty_d = dirty_q;
        if (srv_valid) begin
            dirty_d[srv_tbl] = 1'b0;
        end
        for (int t = 0; t < NT; t++) begin
            if ((pend_d[t] & ~after_rd[t]) != '0) begin
                dirty_d[t] = 1'b1;
            end
        end
        wr_to_rd = 1'b0;
        for (int w = 0; w < NWR; w++) begin
            if (wr_hit[w] && (wr_tbl[w] == rd_tbl)) begin
                wr_to_rd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            dirty_q <= '0;
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            pend_q  <= pend_d;
            dirty_q <= dirty_d;
            rsp_v_q <= rd_valid;
            rsp_d_q <= claim ? pend_q[rd_tbl] : '0;
        end
    end

    assign pend         = pend_q;
    assign dirty        = dirty_q;
    assign rd_rsp_valid = rsp_v_q;
    assign rd_rsp_data  = rsp_d_q;

    // R7: every read is answered on the next cycle
    a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_rsp_valid);

    // R7: a claimed table with no competing write is empty afterwards
    a_r7_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !wr_to_rd) |=> (pend_q[$past(rd_tbl)] == '0));

    // R8: the last write port wins on its bit
    a_r8_last_port_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[NWR-1] && !wr_clr[NWR-1])
        |=> pend_q[$past(wr_tbl[NWR-1])][$past(wr_bit[NWR-1])]);

endmodule

// File: rtl/itsp_bcast_fsm.sv
module itsp_bcast_fsm #(
    parameter int                NT         = 4,
    parameter int                MW         = 64,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] TBL_BASE   = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] TBL_STRIDE = 32'h0000_1000,
    localparam int               TW         = $clog2(NT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NT-1:0]         dirty,
    input  logic [NT-1:0][MW-1:0] pend,
    output logic                  srv_valid,
    output logic [TW-1:0]         srv_tbl,
    output logic                  bc_valid,
    output logic [ADDR_W-1:0]     bc_addr,
    output logic [MW-1:0]         bc_mask
);
    import itsp_pkg::*;

    bc_state_e         state_q, state_d;
    logic [TW-1:0]     rr_q;
    logic [TW-1:0]     pick;
    logic [TW-1:0]     cand;
    logic [ADDR_W-1:0] addr_q;
    logic [MW-1:0]     mask_q;

    // round-robin search starting at rr_q
    always_comb begin
        pick = '0;
        cand = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            cand = rr_q + TW'(i);
            if (dirty[cand]) begin
                pick = cand;
            end
        end
        srv_valid = |dirty;
        srv_tbl   = pick;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BC_IDLE: state_d = srv_valid ? BC_SEND : BC_IDLE;
            BC_SEND: state_d = srv_valid ? BC_SEND : BC_IDLE;
            default: state_d = BC_IDLE;
        endcase
    end

    // state register and broadcast payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BC_IDLE;
            rr_q    <= '0;
            addr_q  <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (srv_valid) begin
                rr_q   <= pick + TW'(1);
                addr_q <= TBL_BASE + (ADDR_W'(pick) * TBL_STRIDE);
                mask_q <= pend[pick];
            end
        end
    end

    // outputs
    always_comb begin
        bc_valid = (state_q == BC_SEND);
        bc_addr  = addr_q;
        bc_mask  = mask_q;
    end

    // R5: a changed table always yields a broadcast on the next cycle
    a_r5_change_brings_bc: assert property (@(posedge clk) disable iff (!rst_n)
        (|dirty) |=> bc_valid);

    // R5: no broadcast without a changed table one cycle earlier
    a_r5_no_spurious_bc: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> $past(|dirty));

endmodule

// File: rtl/itsp_core_snoop.sv
module itsp_core_snoop #(
    parameter int MW     = 64,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bc_valid,
    input  logic [ADDR_W-1:0] bc_addr,
    input  logic [MW-1:0]     bc_mask,
    input  logic [ADDR_W-1:0] tbl_ptr,
    output logic              cap_valid,
    output logic [MW-1:0]     cap_mask
);

    logic          match;
    logic          v_q;
    logic [MW-1:0] m_q;

    assign match = bc_valid && (bc_addr == tbl_ptr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            m_q <= '0;
        end else begin
            v_q <= match;
            if (match) begin
                m_q <= bc_mask;
            end
        end
    end

    assign cap_valid = v_q;
    assign cap_mask  = m_q;

    // R4: a capture only follows a matching broadcast
    a_r4_capture_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> ($past(bc_valid) && ($past(bc_addr) == $past(tbl_ptr))));

    // R4: a non-matching broadcast is never captured
    a_r4_skip_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && (bc_addr != tbl_ptr)) |=> !cap_valid);

endmodule

// File: rtl/itsp_service_port.sv
module itsp_service_port #(
    parameter int                NUM_TABLES = 4,
    parameter int                MASK_W     = 64,
    parameter int                NUM_WR     = 2,
    parameter int                NUM_CORES  = 2,
    parameter int                ADDR_W     = 32,
    parameter int                APT_BITS   = 12,
    parameter logic [ADDR_W-1:0] APT_BASE   = 32'hFEE0_0000,
    parameter logic [ADDR_W-1:0] TBL_BASE   = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] TBL_STRIDE = 32'h0000_1000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WR-1:0]             wr_valid,
    input  logic [NUM_WR*ADDR_W-1:0]      wr_addr,
    input  logic [NUM_WR*64-1:0]          wr_data,
    input  logic                          rd_valid,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic                          rd_rsp_valid,
    output logic [MASK_W-1:0]             rd_rsp_data,
    output logic                          bc_valid,
    output logic [ADDR_W-1:0]             bc_addr,
    output logic [MASK_W-1:0]             bc_mask,
    input  logic [NUM_CORES*ADDR_W-1:0]   core_tbl_ptr,
    output logic [NUM_CORES-1:0]          core_cap_valid,
    output logic [NUM_CORES*MASK_W-1:0]   core_cap_mask
);
    import itsp_pkg::*;

    localparam int TW = $clog2(NUM_TABLES);
    localparam int BW = $clog2(MASK_W);

    logic [NUM_WR-1:0]                 dec_hit;
    logic [NUM_WR-1:0]                 dec_clr;
    logic [NUM_WR-1:0][TW-1:0]         dec_tbl;
    logic [NUM_WR-1:0][BW-1:0]         wr_bit;
    logic [NUM_WR-1:0]                 wr_hit;
    logic                              rd_hit;
    logic                              rd_clr_unused;
    logic [TW-1:0]                     rd_tbl;
    logic [NUM_TABLES-1:0][MASK_W-1:0] pend;
    logic [NUM_TABLES-1:0]             dirty;
    logic                              srv_valid;
    logic [TW-1:0]                     srv_tbl;
    logic                              msg_fields_unused;

    // Message fields that do not steer the pending state
    assign msg_fields_unused = ^{wr_data};

    for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
        itsp_apt_decode #(
            .ADDR_W(ADDR_W), .APT_BITS(APT_BITS), .TW(TW), .APT_BASE(APT_BASE)
        ) u_dec (
            .addr (wr_addr[w*ADDR_W +: ADDR_W]),
            .hit  (dec_hit[w]),
            .clr  (dec_clr[w]),
            .tbl  (dec_tbl[w])
        );
        assign wr_bit[w] = wr_data[w*MSG_W + ISR_LSB +: BW];
        assign wr_hit[w] = wr_valid[w] && dec_hit[w];
    end

    itsp_apt_decode #(
        .ADDR_W(ADDR_W), .APT_BITS(APT_BITS), .TW(TW), .APT_BASE(APT_BASE)
    ) u_rd_dec (
        .addr (rd_addr),
        .hit  (rd_hit),
        .clr  (rd_clr_unused),
        .tbl  (rd_tbl)
    );

    itsp_table_bank #(
        .NT(NUM_TABLES), .MW(MASK_W), .NWR(NUM_WR)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (wr_hit),
        .wr_clr       (dec_clr),
        .wr_tbl       (dec_tbl),
        .wr_bit       (wr_bit),
        .rd_valid     (rd_valid),
        .rd_hit       (rd_hit),
        .rd_tbl       (rd_tbl),
        .srv_valid    (srv_valid),
        .srv_tbl      (srv_tbl),
        .pend         (pend),
        .dirty        (dirty),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data)
    );

    itsp_bcast_fsm #(
        .NT(NUM_TABLES), .MW(MASK_W), .ADDR_W(ADDR_W),
        .TBL_BASE(TBL_BASE), .TBL_STRIDE(TBL_STRIDE)
    ) u_bcast (
        .clk       (clk),
        .rst_n     (rst_n),
        .dirty     (dirty),
        .pend      (pend),
        .srv_valid (srv_valid),
        .srv_tbl   (srv_tbl),
        .bc_valid  (bc_valid),
        .bc_addr   (bc_addr),
        .bc_mask   (bc_mask)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        itsp_core_snoop #(.MW(MASK_W), .ADDR_W(ADDR_W)) u_snoop (
            .clk       (clk),
            .rst_n     (rst_n),
            .bc_valid  (bc_valid),
            .bc_addr   (bc_addr),
            .bc_mask   (bc_mask),
            .tbl_ptr   (core_tbl_ptr[c*ADDR_W +: ADDR_W]),
            .cap_valid (core_cap_valid[c]),
            .cap_mask  (core_cap_mask[c*MASK_W +: MASK_W])
        );
    end

endmodule

// File: tb/itsp_service_port_tb_top.sv
module itsp_service_port_tb_top;

    localparam logic [31:0] APT = 32'hFEE0_0000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   wr_valid;
    logic [63:0]  wr_addr;
    logic [127:0] wr_data;
    logic         rd_valid;
    logic [31:0]  rd_addr;
    logic         rd_rsp_valid;
    logic [63:0]  rd_rsp_data;
    logic         bc_valid;
    logic [31:0]  bc_addr;
    logic [63:0]  bc_mask;
    logic [63:0]  core_tbl_ptr;
    logic [1:0]   core_cap_valid;
    logic [127:0] core_cap_mask;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    itsp_service_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .bc_valid(bc_valid), .bc_addr(bc_addr), .bc_mask(bc_mask),
        .core_tbl_ptr(core_tbl_ptr),
        .core_cap_valid(core_cap_valid), .core_cap_mask(core_cap_mask)
    );

    function automatic logic [31:0] sa(input int t);
        return APT + 32'(t * 16);
    endfunction
    function automatic logic [31:0] ca(input int t);
        return APT + 32'(t * 16) + 32'd8;
    endfunction
    function automatic logic [31:0] ta(input int t);
        return 32'h8000_0000 + 32'(t * 32'h1000);
    endfunction
    function automatic logic [63:0] msg(input logic [7:0] isr, input logic [2:0] pr,
                                        input logic [1:0] pv, input logic [31:0] pl);
        return {19'b0, pv, pr, isr, pl};
    endfunction
    function automatic logic [63:0] bitm(input int b);
        return 64'd1 << b;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wcyc(input logic v0, input logic [31:0] a0, input logic [63:0] d0,
                        input logic v1, input logic [31:0] a1, input logic [63:0] d1);
        wr_valid = {v1, v0};
        wr_addr  = {a1, a0};
        wr_data  = {d1, d0};
        @(negedge clk);
        wr_valid = '0;
    endtask

    task automatic read_tbl(input logic [31:0] a, input logic [63:0] exp, input string req);
        rd_valid = 1'b1;
        rd_addr  = a;
        @(negedge clk);
        rd_valid = 1'b0;
        chk({req, " rsp valid"}, 64'(rd_rsp_valid), 64'd1);
        chk({req, " rsp data"}, rd_rsp_data, exp);
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        wr_valid = '0;
        wr_addr  = '0;
        wr_data  = '0;
        rd_valid = 1'b0;
        rd_addr  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 bc_valid", 64'(bc_valid), 64'd0);
        chk("R1 rd_rsp_valid", 64'(rd_rsp_valid), 64'd0);
        chk("R1 cap_valid", 64'(core_cap_valid), 64'd0);
        for (int t = 0; t < 4; t++) read_tbl(sa(t), 64'd0, "R1 empty table");
    endtask

    task automatic t_set_bcast();
        wcyc(1'b1, sa(0), msg(8'd3, 3'd1, 2'd0, 32'h1111), 1'b0, '0, '0);
        chk("R5 no bc same cycle", 64'(bc_valid), 64'd0);
        @(negedge clk);
        chk("R5 bc valid", 64'(bc_valid), 64'd1);
        chk("R5 bc addr", 64'(bc_addr), 64'(ta(0)));
        chk("R5 bc mask", bc_mask, bitm(3));
        @(negedge clk);
        chk("R4 core0 cap", 64'(core_cap_valid), 64'b01);
        chk("R4 core0 mask", core_cap_mask[63:0], bitm(3));
        drain();
        read_tbl(sa(0), bitm(3), "R7 read returns");
        read_tbl(sa(0), 64'd0, "R7 read claimed");
    endtask

    task automatic t_no_consumer();
        wcyc(1'b1, sa(3), msg(8'd10, 3'd0, 2'd0, 32'h0), 1'b0, '0, '0);
        @(negedge clk);
        chk("R3 bc addr t3", 64'(bc_addr), 64'(ta(3)));
        @(negedge clk);
        chk("R3 no capture", 64'(core_cap_valid), 64'd0);
        drain();
        read_tbl(sa(3), bitm(10), "R3 kept pending");
    endtask

    task automatic t_clear();
        wcyc(1'b1, sa(1), msg(8'd4, 3'd0, 2'd0, 32'h0), 1'b1, sa(1), msg(8'd7, 3'd0, 2'd0, 32'h0));
        drain();
        wcyc(1'b1, ca(1), msg(8'd4, 3'd0, 2'd0, 32'h0), 1'b0, '0, '0);
        @(negedge clk);
        chk("R5 drop gives no bc", 64'(bc_valid), 64'd0);
        read_tbl(sa(1), bitm(7), "R2 drop clears bit");
    endtask

    task automatic t_outside();
        wcyc(1'b1, APT - 32'd16, msg(8'd1, 3'd0, 2'd0, 32'h0),
             1'b1, APT + 32'h100, msg(8'd1, 3'd0, 2'd0, 32'h0));
        @(negedge clk);
        chk("R2 outside no bc", 64'(bc_valid), 64'd0);
        read_tbl(sa(0), 64'd0, "R2 outside t0");
        read_tbl(sa(1), 64'd0, "R2 outside t1");
        read_tbl(APT + 32'h2000, 64'd0, "R7 read outside");
    endtask

    task automatic t_fields();
        wcyc(1'b1, sa(2), msg(8'hC5, 3'd7, 2'd3, 32'hDEAD_BEEF), 1'b0, '0, '0);
        drain();
        wcyc(1'b0, '0, '0, 1'b1, sa(2), msg(8'h05, 3'd0, 2'd0, 32'h0));
        @(negedge clk);
        chk("R5 already set no bc", 64'(bc_valid), 64'd0);
        read_tbl(sa(2), bitm(5), "R9 fields ignored");
    endtask

    task automatic t_order();
        wcyc(1'b1, sa(0), msg(8'd20, 3'd0, 2'd0, 32'h0), 1'b1, ca(0), msg(8'd20, 3'd0, 2'd0, 32'h0));
        @(negedge clk);
        chk("R8 set then drop no bc", 64'(bc_valid), 64'd0);
        read_tbl(sa(0), 64'd0, "R8 drop wins");
        wcyc(1'b1, ca(0), msg(8'd21, 3'd0, 2'd0, 32'h0), 1'b1, sa(0), msg(8'd21, 3'd0, 2'd0, 32'h0));
        @(negedge clk);
        chk("R8 drop then set bc", bc_mask, bitm(21));
        read_tbl(sa(0), bitm(21), "R8 set wins");
        drain();
        wcyc(1'b1, sa(1), msg(8'd2, 3'd0, 2'd0, 32'h0), 1'b0, '0, '0);
        drain();
        rd_valid = 1'b1;
        rd_addr  = sa(1);
        wcyc(1'b1, sa(1), msg(8'd3, 3'd0, 2'd0, 32'h0), 1'b0, '0, '0);
        rd_valid = 1'b0;
        chk("R8 read before write", rd_rsp_data, bitm(2));
        drain();
        read_tbl(sa(1), bitm(3), "R8 write survives claim");
    endtask

    task automatic t_rr();
        do_reset();
        wcyc(1'b1, sa(3), msg(8'd0, 3'd0, 2'd0, 32'h0), 1'b1, sa(1), msg(8'd0, 3'd0, 2'd0, 32'h0));
        @(negedge clk);
        chk("R6 first t1", 64'(bc_addr), 64'(ta(1)));
        @(negedge clk);
        chk("R6 second t3", 64'(bc_addr), 64'(ta(3)));
        chk("R6 second valid", 64'(bc_valid), 64'd1);
        @(negedge clk);
        chk("R6 idle", 64'(bc_valid), 64'd0);
        wcyc(1'b1, sa(2), msg(8'd0, 3'd0, 2'd0, 32'h0), 1'b1, sa(0), msg(8'd0, 3'd0, 2'd0, 32'h0));
        @(negedge clk);
        chk("R6 wrap t0", 64'(bc_addr), 64'(ta(0)));
        @(negedge clk);
        chk("R6 then t2", 64'(bc_addr), 64'(ta(2)));
        drain();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        core_tbl_ptr = {ta(2), ta(0)};
        do_reset();
        t_reset();
        t_set_bcast();
        t_no_consumer();
        t_clear();
        t_outside();
        t_fields();
        t_order();
        t_rr();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule